// File: doc/BRIEF.md
# Two-Tap Averaging Comb Filter

This block is a streaming low-pass filter. Each accepted sample is added to the sample accepted just before it, and the sum is halved, so the output is y(n) = (x(n) + x(n-1)) / 2. The transfer function is (1 + z^-1) / 2. Samples are signed two's-complement words. A valid strobe marks each sample the block should take in. The block returns each result one clock later with a matching valid strobe.

The one-sample memory is a register triggered on the rising clock edge. The clock runs all the time. The register only loads a new value when the input strobe is high, and otherwise keeps what it has. The sum is formed one bit wider than a sample. Halving is an arithmetic right shift, which rounds toward negative infinity. After reset the stored previous sample is zero.

Top module: `avg2_comb`

## Requirements
- R1: While reset is high, and in the first cycle after reset is released with no input, out_valid is 0, out_sample is 0 and the stored previous sample is 0.
- R2: When in_valid is high at a rising edge, out_sample after that edge equals floor((x + p) / 2). Here x is in_sample and p is the previously accepted sample, both signed.
- R3: The sum x + p is formed with DATA_W+1 bits, so it cannot overflow. Two full-scale negative samples give the most negative output value, and two full-scale positive samples give the most positive output value.
- R4: Halving rounds toward negative infinity. For example, x + p = -1 gives -1 and x + p = 1 gives 0.
- R5: out_valid after a rising edge equals in_valid before that edge, so the latency is exactly one cycle.
- R6: When in_valid is low, out_sample and the stored previous sample keep their values. The next accepted sample is averaged with the last accepted sample, not with anything driven while in_valid was low.
- R7: The first sample accepted after reset is averaged with zero, so the output is floor(x/2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock; all registers load on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | High when in_sample holds a sample to accept |
| in_sample | input | DATA_W | Signed input sample |
| out_valid | output | 1 | High for one cycle for each accepted sample |
| out_sample | output | DATA_W | Signed averaged sample |

## Verification
The bench builds the block with DATA_W = 4. At that width the full-scale values -8 and +7 come up often in random draws, and so do odd sums that exercise the rounding. The default width of 16 is also covered by elaboration. Bubbles in in_valid are drawn at random. This means hold cycles occur between accepted samples, and the skipped samples carry values that would spoil the average if they were wrongly taken in.

// File: rtl/avg2_pkg.sv
package avg2_pkg;
  // Adds two signed samples with one guard bit.
  function automatic logic signed [32:0] wide_add(input logic signed [31:0] a,
                                                  input logic signed [31:0] b);
    wide_add = 33'(a) + 33'(b);
  endfunction
endpackage

// File: rtl/avg2_delay.sv
module avg2_delay #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
endmodule

// File: rtl/avg2_sum.sv
module avg2_sum #(
  parameter int DATA_W = 16,
  localparam int SUM_W = DATA_W + 1
) (
  input  logic signed [DATA_W-1:0] a,
  input  logic signed [DATA_W-1:0] b,
  output logic signed [SUM_W-1:0]  sum,
  output logic signed [DATA_W-1:0] half
);
  function automatic logic signed [SUM_W-1:0] add_wide(
      input logic signed [DATA_W-1:0] x, input logic signed [DATA_W-1:0] y);
    add_wide = SUM_W'(x) + SUM_W'(y);
  endfunction

  function automatic logic signed [DATA_W-1:0] halve(input logic signed [SUM_W-1:0] s);
    logic signed [SUM_W-1:0] t;
    t = s >>> 1;
    halve = t[DATA_W-1:0];
  endfunction

  always_comb begin
    sum  = add_wide(a, b);
    half = halve(sum);
  end

  // R3
  no_overflow_chk: assert final ((sum >>> 1) >= SUM_W'(-(2 ** (DATA_W-1)))
                                 && (sum >>> 1) <= SUM_W'(2 ** (DATA_W-1) - 1));
endmodule

// File: rtl/avg2_comb.sv
module avg2_comb #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_sample
);
  localparam int SUM_W = DATA_W + 1;

  logic [DATA_W-1:0]        prev_q;
  logic signed [SUM_W-1:0]  sum_w;
  logic signed [DATA_W-1:0] half_w;
  logic                     accept_w;

  assign accept_w = in_valid;

  avg2_delay #(.DATA_W(DATA_W)) u_delay (
    .clk(clk), .rst(rst), .load(accept_w), .d(in_sample), .q(prev_q)
  );

  avg2_sum #(.DATA_W(DATA_W)) u_sum (
    .a(in_sample), .b(prev_q), .sum(sum_w), .half(half_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= accept_w;
      if (accept_w) out_sample <= half_w;
    end
  end

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R5
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_sample));
  // R2
  delay_track_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> prev_q == $past(in_sample));
endmodule

// File: tb/sim_avg2_comb.sv
module sim_avg2_comb;
  localparam int W = 4;
  logic clk = 0, rst = 1, in_valid = 0;
  logic [W-1:0] in_sample = '0;
  logic out_valid;
  logic [W-1:0] out_sample;
  int total = 0, bad = 0;
  int prev_m = 0, last_out = 0;
  bit done = 0;

  avg2_comb #(.DATA_W(W)) u0 (.clk(clk), .rst(rst), .in_valid(in_valid),
    .in_sample(in_sample), .out_valid(out_valid), .out_sample(out_sample));

  always #5 clk = ~clk;

  function automatic int sx(input logic [W-1:0] v);
    return (v >= 2**(W-1)) ? int'(v) - 2**W : int'(v);
  endfunction

  function automatic int floor_half(input int s);
    return (s >= 0) ? s / 2 : -((-s + 1) / 2);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drives one cycle, then samples the outputs at the falling edge.
  task automatic step(input logic v, input int x, input string req);
    in_valid  = v;
    in_sample = W'(x);
    @(posedge clk); #1;
    @(negedge clk);
    check({req, "_valid"}, int'(out_valid), int'(v));
    if (v) begin
      last_out = floor_half(x + prev_m);
      prev_m = x;
    end
    check({req, "_data"}, sx(out_sample), last_out);
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    check("R1_valid_rst", int'(out_valid), 0);
    check("R1_data_rst", sx(out_sample), 0);
    rst = 0;
    @(negedge clk);
    check("R1_idle", int'(out_valid), 0);
    step(1, 5, "R7");         // floor(5/2)=2
    step(1, -6, "R4");        // -1 -> -1
    step(1, 7, "R4p");        // 1 -> 0
    step(0, -8, "R6");        // ignored
    step(1, 7, "R6b");        // 7+7 -> 7, not influenced by -8
    step(1, 7, "R3pos");
    step(1, -8, "R3mix");
    step(1, -8, "R3neg");     // -8
    step(1, -8, "R2");
    for (int i = 0; i < 400; i++) begin
      logic v;
      v = ($urandom % 3) != 0;
      step(v, sx(W'($urandom)), v ? "R2" : "R6");
    end
    step(0, 3, "R5");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule